// File: doc/BRIEF.md
# Privileged Machine State Register Unit

This block keeps a 64-bit machine state word for a processor core and carries out the side effects of a privileged write to it. A write is not stored as given. The incoming value first passes a static writable-bit mask. The hypervisor bit is protected. In server mode, entering user state forces the relocation and interrupt-enable bits on. The difference between the old and new values drives three one-cycle requests: a translation flush, a swap of four shadow general registers, and a halt. A write can also move the exception vector base.

The stored word also yields two 3-bit MMU context indices, one for instruction fetch and one for data access. The mode select chooses how these indices and the flush rule are formed: server style or embedded style. Every control bit position is a parameter. The shadow-register swap is a generate-time option.

Top module: `mstate_unit`

## Requirements
- R1: After reset the state equals parameter RST_STATE (zero by default) and the flush, swap and halt outputs are 0. The vector base is 0xFFF00000 if the EP bit of RST_STATE is 1, otherwise 0x00000000.
- R2: A written value is ANDed with wr_mask_i before it is stored. Bits outside the mask read 0, except bits forced by R3 and R7.
- R3: The HV bit keeps its old value unless the write has alter_hv_i=1 and the old HV bit is 1. In that case HV takes the masked data bit.
- R4: flush_o pulses when the masked, HV-protected value differs from the old state in IR or DR. In embedded mode (embedded_i=1) a difference in GS also pulses it. Bits forced later by R7 do not count toward this difference.
- R5: With HAS_SHADOW=1, swap_o pulses when the TGPR bit of the new value differs from the old one.
- R6: vec_base_o becomes 0xFFF00000 when a write changes EP to 1, and 0x00000000 when a write changes EP to 0.
- R7: In server mode (embedded_i=0), a stored value with PR=1 has EE, DR and IR forced to 1. Embedded mode never forces them.
- R8: halt_o pulses when the stored value has POW=1, irq_pend_i=0 and pd_ok_i=1, all sampled with the write.
- R9: Data index bits are as follows. Bit 0 = !PR. Bit 2 = HV (server) or GS (embedded). Bit 1 = !DR (server) or DS (embedded).
- R10: Instruction index bits 0 and 2 match the data index. Bit 1 = !IR (server) or IS (embedded).
- R11: State, vector base and indices change on the clock edge that samples wr_en_i=1. The flush, swap and halt outputs are high for exactly that one cycle. Without a write nothing changes and the pulses stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Privileged write strobe |
| wr_data_i | input | 64 | Value to write |
| alter_hv_i | input | 1 | Write may change the HV bit |
| wr_mask_i | input | 64 | Static writable-bit mask |
| embedded_i | input | 1 | 1 = embedded style, 0 = server style |
| irq_pend_i | input | 1 | An interrupt is pending |
| pd_ok_i | input | 1 | Power-down is permitted |
| state_o | output | 64 | Machine state word |
| flush_o | output | 1 | One-cycle translation flush request |
| swap_o | output | 1 | One-cycle shadow register swap request |
| vec_base_o | output | 32 | Exception vector base |
| halt_o | output | 1 | One-cycle halt request |
| immu_idx_o | output | 3 | Instruction-side MMU context index |
| dmmu_idx_o | output | 3 | Data-side MMU context index |

## Verification
The bench builds the unit with RST_STATE holding only the HV bit, because with a zero reset HV could never be set and the R3 path and the server-side bit 2 of the indices would stay out of reach. It keeps HAS_SHADOW=1 and uses a mask that clears the top three bits and bit 40, so masking is visible on an all-ones write. The embedded space bits share the IR and DR positions, as the defaults give. A mode switch therefore changes the meaning of the same stored bits, and the bench exercises that by moving between modes within one run.

// File: rtl/mstate_pkg.sv
package mstate_pkg;

   typedef logic [2:0] mmu_ctx_t;

   typedef struct packed {
      logic flush;
      logic swap;
      logic halt;
   } mstate_fx_t;

   function automatic logic [31:0] vec_base_of(input logic ep, input logic [31:0] hi);
      return ep ? hi : 32'h0;
   endfunction

endpackage

// File: rtl/mstate_wr_filter.sv
module mstate_wr_filter #(
   parameter int unsigned XLEN = 64,
   parameter int unsigned PR_B = 14,
   parameter int unsigned HV_B = 60,
   parameter int unsigned IR_B = 5,
   parameter int unsigned DR_B = 4,
   parameter int unsigned EE_B = 15
) (
   input  logic [XLEN-1:0] cur_i,
   input  logic [XLEN-1:0] data_i,
   input  logic [XLEN-1:0] mask_i,
   input  logic            alter_hv_i,
   input  logic            embedded_i,
   output logic [XLEN-1:0] pre_o,
   output logic [XLEN-1:0] fin_o
);
   logic hv_free;

   assign hv_free = alter_hv_i & cur_i[HV_B];

   always_comb begin
      pre_o       = data_i & mask_i;
      if (!hv_free) begin
         pre_o[HV_B] = cur_i[HV_B];
      end
      fin_o = pre_o;
      if (!embedded_i && pre_o[PR_B]) begin
         fin_o[EE_B] = 1'b1;
         fin_o[DR_B] = 1'b1;
         fin_o[IR_B] = 1'b1;
      end
   end
endmodule

// File: rtl/mstate_fx_gen.sv
module mstate_fx_gen
   import mstate_pkg::*;
#(
   parameter bit HAS_SHADOW = 1'b1
) (
   input  logic       d_ir_i,
   input  logic       d_dr_i,
   input  logic       d_gs_i,
   input  logic       d_tgpr_i,
   input  logic       pow_i,
   input  logic       irq_pend_i,
   input  logic       pd_ok_i,
   input  logic       embedded_i,
   output mstate_fx_t fx_o
);
   logic swap_w;

   generate
      if (HAS_SHADOW) begin : g_shadow
         assign swap_w = d_tgpr_i;
      end else begin : g_no_shadow
         logic unused_tgpr;
         assign unused_tgpr = d_tgpr_i;
         assign swap_w      = 1'b0;
      end
   endgenerate

   assign fx_o.flush = d_ir_i | d_dr_i | (embedded_i & d_gs_i);
   assign fx_o.swap  = swap_w;
   assign fx_o.halt  = pow_i & ~irq_pend_i & pd_ok_i;
endmodule

// File: rtl/mstate_ctx_idx.sv
module mstate_ctx_idx
   import mstate_pkg::*;
(
   input  logic     pr_i,
   input  logic     hv_i,
   input  logic     gs_i,
   input  logic     xlate_i,
   input  logic     space_i,
   input  logic     embedded_i,
   output mmu_ctx_t idx_o
);
   assign idx_o[0] = ~pr_i;
   assign idx_o[1] = embedded_i ? space_i : ~xlate_i;
   assign idx_o[2] = embedded_i ? gs_i : hv_i;
endmodule

// File: rtl/mstate_unit.sv
module mstate_unit
   import mstate_pkg::*;
#(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned VEC_W      = 32,
   parameter logic [31:0] VEC_HI     = 32'hFFF0_0000,
   parameter logic [63:0] RST_STATE  = 64'h0,
   parameter bit          HAS_SHADOW = 1'b1,
   parameter int unsigned PR_B       = 14,
   parameter int unsigned HV_B       = 60,
   parameter int unsigned IR_B       = 5,
   parameter int unsigned DR_B       = 4,
   parameter int unsigned EE_B       = 15,
   parameter int unsigned EP_B       = 6,
   parameter int unsigned GS_B       = 28,
   parameter int unsigned IS_B       = 5,
   parameter int unsigned DS_B       = 4,
   parameter int unsigned TGPR_B     = 17,
   parameter int unsigned POW_B      = 18
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [63:0]      wr_data_i,
   input  logic             alter_hv_i,
   input  logic [63:0]      wr_mask_i,
   input  logic             embedded_i,
   input  logic             irq_pend_i,
   input  logic             pd_ok_i,
   output logic [63:0]      state_o,
   output logic             flush_o,
   output logic             swap_o,
   output logic [31:0]      vec_base_o,
   output logic             halt_o,
   output logic [2:0]       immu_idx_o,
   output logic [2:0]       dmmu_idx_o
);
   localparam int unsigned MAX_B = XLEN - 1;

   initial begin
      a_xlen : assert (XLEN == 64 && VEC_W == 32);
      a_bits : assert (PR_B <= MAX_B && HV_B <= MAX_B && IR_B <= MAX_B && DR_B <= MAX_B &&
                       EE_B <= MAX_B && EP_B <= MAX_B && GS_B <= MAX_B && IS_B <= MAX_B &&
                       DS_B <= MAX_B && TGPR_B <= MAX_B && POW_B <= MAX_B);
      a_distinct : assert (PR_B != HV_B && PR_B != IR_B && PR_B != DR_B && PR_B != EE_B &&
                           IR_B != DR_B && EE_B != IR_B && EE_B != DR_B);
   end

   logic [XLEN-1:0] state_q, pre_w, fin_w, diff_w;
   logic [VEC_W-1:0] vec_q;
   mstate_fx_t      fx_w, fx_q;
   mmu_ctx_t        iidx_w, didx_w;

   mstate_wr_filter #(
      .XLEN(XLEN), .PR_B(PR_B), .HV_B(HV_B), .IR_B(IR_B), .DR_B(DR_B), .EE_B(EE_B)
   ) filt_i (
      .cur_i      (state_q),
      .data_i     (wr_data_i),
      .mask_i     (wr_mask_i),
      .alter_hv_i (alter_hv_i),
      .embedded_i (embedded_i),
      .pre_o      (pre_w),
      .fin_o      (fin_w)
   );

   assign diff_w = pre_w ^ state_q;

   mstate_fx_gen #(.HAS_SHADOW(HAS_SHADOW)) fx_i (
      .d_ir_i     (diff_w[IR_B]),
      .d_dr_i     (diff_w[DR_B]),
      .d_gs_i     (diff_w[GS_B]),
      .d_tgpr_i   (diff_w[TGPR_B]),
      .pow_i      (fin_w[POW_B]),
      .irq_pend_i (irq_pend_i),
      .pd_ok_i    (pd_ok_i),
      .embedded_i (embedded_i),
      .fx_o       (fx_w)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= RST_STATE;
         vec_q   <= vec_base_of(RST_STATE[EP_B], VEC_HI);
         fx_q    <= '0;
      end else begin
         fx_q <= wr_en_i ? fx_w : '0;
         if (wr_en_i) begin
            state_q <= fin_w;
            if (diff_w[EP_B]) begin
               vec_q <= vec_base_of(pre_w[EP_B], VEC_HI);
            end
         end
      end
   end

   generate
      for (genvar s = 0; s < 2; s++) begin : g_side
         localparam int unsigned XL_B = (s == 0) ? IR_B : DR_B;
         localparam int unsigned SP_B = (s == 0) ? IS_B : DS_B;
         mmu_ctx_t idx_w;
         mstate_ctx_idx ctx_i (
            .pr_i       (state_q[PR_B]),
            .hv_i       (state_q[HV_B]),
            .gs_i       (state_q[GS_B]),
            .xlate_i    (state_q[XL_B]),
            .space_i    (state_q[SP_B]),
            .embedded_i (embedded_i),
            .idx_o      (idx_w)
         );
         if (s == 0) begin : g_inst
            assign iidx_w = idx_w;
         end else begin : g_data
            assign didx_w = idx_w;
         end
      end
   endgenerate

   assign state_o    = state_q;
   assign vec_base_o = vec_q;
   assign flush_o    = fx_q.flush;
   assign swap_o     = fx_q.swap;
   assign halt_o     = fx_q.halt;
   assign immu_idx_o = iidx_w;
   assign dmmu_idx_o = didx_w;

   p_hv_kept_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !(alter_hv_i && state_q[HV_B])) |=> (state_q[HV_B] == $past(state_q[HV_B])));

   p_flush_src_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |-> $past(wr_en_i));

   p_swap_toggle_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      swap_o |-> (state_q[TGPR_B] != $past(state_q[TGPR_B])));

   p_vec_base_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_q == (state_q[EP_B] ? VEC_HI : 32'h0));

   p_user_force_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !embedded_i) |=> (!state_q[PR_B] || (state_q[EE_B] && state_q[DR_B] && state_q[IR_B])));

   p_halt_cond_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      halt_o |-> (state_q[POW_B] && !$past(irq_pend_i) && $past(pd_ok_i)));

   p_idx_shared_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (immu_idx_o[0] == dmmu_idx_o[0]) && (immu_idx_o[2] == dmmu_idx_o[2]));

   p_hold_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> ($stable(state_q) && !flush_o && !swap_o && !halt_o));
endmodule

// File: tb/mstate_unit_tb.sv
module mstate_unit_tb_top;
   localparam int PR = 14, HV = 60, IR = 5, DR = 4, EE = 15, EP = 6;
   localparam int GS = 28, IS = 5, DS = 4, TGPR = 17, POW = 18;
   localparam logic [63:0] RSTV = 64'h1 << HV;
   localparam logic [63:0] MASK = 64'h1FFF_FEFF_FFFF_FFFF;
   localparam int NV = 14;
   // {embedded, alter_hv, irq_pend, pd_ok, data}
   localparam logic [67:0] VEC [NV] = '{
      {4'b0000, 64'h0000_0000_0000_0030},
      {4'b0000, 64'h0000_0000_0000_4000},
      {4'b0000, 64'h0000_0000_0002_C070},
      {4'b0001, 64'h0000_0000_0004_C030},
      {4'b0011, 64'h0000_0000_0004_C030},
      {4'b0000, 64'h0000_0000_0004_C030},
      {4'b0100, 64'h0000_0000_0000_0000},
      {4'b0100, 64'h1000_0000_0000_0000},
      {4'b0001, 64'hFFFF_FFFF_FFFF_FFFF},
      {4'b1000, 64'h0000_0000_1000_0000},
      {4'b1000, 64'h0000_0000_1000_4020},
      {4'b1000, 64'h0000_0000_1000_0010},
      {4'b1000, 64'h0000_0000_1000_0010},
      {4'b0000, 64'h0000_0000_0000_0000}
   };

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, alter = 1'b0, emb = 1'b0, irq = 1'b0, pd = 1'b0;
   logic [63:0] data = '0;
   logic [63:0] st;
   logic fl, sw, hl;
   logic [31:0] vb;
   logic [2:0] ii, di;
   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [63:0] model = RSTV;

   always #4 clk = ~clk;

   mstate_unit #(.RST_STATE(RSTV), .HAS_SHADOW(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(data), .alter_hv_i(alter),
      .wr_mask_i(MASK), .embedded_i(emb), .irq_pend_i(irq), .pd_ok_i(pd),
      .state_o(st), .flush_o(fl), .swap_o(sw), .vec_base_o(vb), .halt_o(hl),
      .immu_idx_o(ii), .dmmu_idx_o(di));

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] idx_of(input logic [63:0] s, input logic e, input bit inst);
      logic [2:0] r;
      r[0] = !s[PR];
      r[2] = e ? s[GS] : s[HV];
      if (inst) r[1] = e ? s[IS] : !s[IR];
      else      r[1] = e ? s[DS] : !s[DR];
      return r;
   endfunction

   task automatic check_all(input string tag, input logic [63:0] es, input bit ef, input bit es_w,
                            input bit eh);
      logic [31:0] ev;
      ev = es[EP] ? 32'hFFF0_0000 : 32'h0;
      chk(st == es, {tag, " R2 R3 R7 state"}, st, es);
      chk(fl == ef, {tag, " R4 flush"}, 64'(fl), 64'(ef));
      chk(sw == es_w, {tag, " R5 swap"}, 64'(sw), 64'(es_w));
      chk(vb == ev, {tag, " R6 vec_base"}, 64'(vb), 64'(ev));
      chk(hl == eh, {tag, " R8 halt"}, 64'(hl), 64'(eh));
      chk(di == idx_of(es, emb, 1'b0), {tag, " R9 dmmu"}, 64'(di), 64'(idx_of(es, emb, 1'b0)));
      chk(ii == idx_of(es, emb, 1'b1), {tag, " R10 immu"}, 64'(ii), 64'(idx_of(es, emb, 1'b1)));
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values, server mode
      check_all("R1 reset", RSTV, 1'b0, 1'b0, 1'b0);

      for (int k = 0; k < NV; k++) begin
         logic [63:0] v, d;
         logic ef, esw, eh;
         {emb, alter, irq, pd, data} = VEC[k];
         wr_en = 1'b1;
         v = data & MASK;
         if (!(alter && model[HV])) v[HV] = model[HV];
         d   = v ^ model;
         ef  = d[IR] | d[DR] | (emb & d[GS]);
         esw = d[TGPR];
         if (!emb && v[PR]) begin v[EE] = 1'b1; v[DR] = 1'b1; v[IR] = 1'b1; end
         eh  = v[POW] & !irq & pd;
         model = v;
         @(negedge clk);
         check_all($sformatf("vec%0d R11", k), model, ef, esw, eh);
      end

      // R11: no write holds everything, pulses drop
      wr_en = 1'b0;
      data  = 64'hFFFF_FFFF_FFFF_FFFF;
      alter = 1'b1;
      repeat (2) @(negedge clk);
      check_all("R11 hold", model, 1'b0, 1'b0, 1'b0);

      // R2: all-ones write in embedded mode, masked bits read zero
      emb = 1'b1; alter = 1'b0; irq = 1'b1; pd = 1'b0;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk((st & ~MASK) == 64'h0, "R2 masked bits", st & ~MASK, 64'h0);
      chk(st[40] == 1'b0, "R2 bit40 masked", 64'(st[40]), 64'h0);

      // R1: reset again in embedded mode
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(st == RSTV, "R1 reset embedded state", st, RSTV);
      chk(di == 3'b001, "R1 R9 reset embedded dmmu", 64'(di), 64'h1);
      chk(ii == 3'b001, "R1 R10 reset embedded immu", 64'(ii), 64'h1);
      chk(vb == 32'h0, "R1 R6 reset vec_base", 64'(vb), 64'h0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule